// File: doc/BRIEF.md
# Write-Combining Store Buffer

This block sits between a processor's store port and a simple bus master. Stores tagged as combinable are gathered into a small ring of line buffers. Each buffer covers one aligned 64-byte line and has a per-byte valid mask. Several stores to the same line fold into one buffer, so the bus carries fewer and larger transfers. A line that ends up fully written leaves as one full-line burst. A line that is only partly written leaves as one 8-byte partial transfer for each chunk that holds data.

The first store to a line that no buffer holds allocates the next ring slot. It also sends an ownership request, tagged with the slot number, to the memory side. A store that would update an older buffer is held while any younger buffer still waits for its ownership answer, so writes become visible in program order. A buffer is never drained before its own ownership answer arrives.

Uncached stores never merge. They wait until every buffer has drained and then go out as a single transfer. A flush pulse drains all buffers oldest first and ends with a one-cycle done pulse. When the ring is full, a store to a new line first forces the oldest buffer out.

Back-pressure on the store port follows valid/ready rules. A store is taken on a clock edge where `st_valid` and `st_ready` are both high. The source must hold all store fields stable while `st_valid` is high and `st_ready` is low. `st_ready` may depend on `st_valid` and on the store's fields. On the bus side, a beat is presented with `bus_req` and stays unchanged until the edge where `bus_ack` is high.

Top module: `wc_store_buffer`

## Requirements
- R1: At most NBUF (4) line buffers are held. A combinable store to a new line while all are held is not accepted until the oldest buffer has fully drained to the bus.
- R2: A line is selected by address bits [31:6], and the 8-byte chunk within it by bits [5:3]. A combinable store to a line already held merges its enabled bytes into that buffer without a new ownership request. A released buffer starts with an empty mask.
- R3: A buffer whose 64 bytes are all valid drains as 8 beats with `bus_full`=1. The beats go in chunk order 0..7, beat k has address line base + 8*k, and each beat carries that chunk's data with `bus_be`=8'hFF.
- R4: A partly valid buffer drains with `bus_full`=0, one beat per chunk that holds any valid byte, in ascending chunk order. Each beat has `bus_be` equal to that chunk's valid bits. A line with 63 valid bytes gives 8 beats.
- R5: A combinable store to a line no buffer holds allocates a buffer. In the next cycle it pulses `rfo_req` for one cycle, with `rfo_addr` set to the line base and `rfo_tag` set to the buffer slot.
- R6: A combinable store that hits a buffer allocated before another buffer whose ownership answer (`rfo_ack` with that slot on `rfo_ack_tag`) is still missing is held with `st_ready`=0 until that answer arrives.
- R7: An uncached store is accepted only after every held buffer has drained. It then produces exactly one beat with `bus_full`=0 and the store's own address, data and byte enables. It issues no ownership request.
- R8: A `flush_req` pulse drains every held buffer in allocation order and then pulses `flush_done` for one cycle. From the cycle after `flush_req` until `flush_done`, no store is accepted.
- R9: A buffer is not put on the bus while its own ownership answer is outstanding.
- R10: While `bus_req` is high and `bus_ack` is low, the next cycle keeps `bus_req` high with address, data, byte enables and `bus_full` unchanged.
- R11: After reset no buffer is held. `bus_req`, `rfo_req` and `flush_done` are low, and a flush completes with `flush_done` and no bus beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| st_valid | input | 1 | Store valid |
| st_ready | output | 1 | Store accepted on this edge when valid is also high |
| st_addr | input | AW | Store byte address, 8-byte aligned |
| st_data | input | 8*BEAT_BYTES | Store data, byte b on bits 8b+7..8b |
| st_be | input | BEAT_BYTES | Store byte enables |
| st_uncached | input | 1 | 1: uncached store, 0: combinable store |
| flush_req | input | 1 | One-cycle request to drain all buffers |
| flush_done | output | 1 | One-cycle pulse when a flush has finished |
| rfo_req | output | 1 | Ownership request pulse |
| rfo_addr | output | AW | Line base address of the request |
| rfo_tag | output | clog2(NBUF) | Buffer slot of the request |
| rfo_ack | input | 1 | Ownership answer pulse |
| rfo_ack_tag | input | clog2(NBUF) | Slot the answer belongs to |
| bus_req | output | 1 | Beat valid on the bus |
| bus_ack | input | 1 | Beat taken on this edge |
| bus_addr | output | AW | Beat address |
| bus_full | output | 1 | Beat belongs to a full-line burst |
| bus_data | output | 8*BEAT_BYTES | Beat data |
| bus_be | output | BEAT_BYTES | Beat byte enables |

## Verification
The combining path is tried with three line shapes: a line written in full, a line with two sparse chunks where one chunk is written twice, and a line missing only its last byte. These shapes show whether the burst/partial choice depends on the whole mask and whether merging reuses the buffer. Five lines in a row to distinct addresses show whether the oldest line is evicted first. An uncached store behind a pending line shows whether program order is kept across the two paths. Withholding ownership answers shows both the cross-buffer stall and the drain gate. A slow acknowledge on the bus shows whether beats are held stable until taken.

// File: rtl/wcsb_pkg.sv
package wcsb_pkg;
  typedef enum logic [1:0] {
    S_IDLE,
    S_DRAIN,
    S_UNCACHED
  } wcsb_state_e;
endpackage

// File: rtl/wcsb_match.sv
// Line lookup and cross-buffer ordering check.
module wcsb_match #(
  parameter int NBUF = 4,
  parameter int LAW  = 26,
  localparam int TAGW = $clog2(NBUF)
) (
  input  logic [NBUF-1:0]          vld,
  input  logic [NBUF-1:0]          rpend,
  input  logic [NBUF-1:0][LAW-1:0] ltag,
  input  logic [TAGW-1:0]          head,
  input  logic [LAW-1:0]           key,
  output logic                     hit,
  output logic [TAGW-1:0]          hit_idx,
  output logic                     order_block
);
  logic [NBUF-1:0][TAGW-1:0] age;

  for (genvar g = 0; g < NBUF; g++) begin : g_age
    assign age[g] = TAGW'(g) - head;
  end

  always_comb begin
    hit = 1'b0;
    hit_idx = '0;
    for (int i = 0; i < NBUF; i++) begin
      if (vld[i] && ltag[i] == key) begin
        hit = 1'b1;
        hit_idx = TAGW'(i);
      end
    end
    order_block = 1'b0;
    for (int j = 0; j < NBUF; j++) begin
      if (hit && vld[j] && rpend[j] && age[j] > age[hit_idx]) order_block = 1'b1;
    end
  end
endmodule

// File: rtl/wcsb_pick.sv
// Lowest-set-bit selector for the next chunk to drain.
module wcsb_pick #(
  parameter int N = 8,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/wc_store_buffer.sv
module wc_store_buffer
  import wcsb_pkg::*;
#(
  parameter int AW         = 32,
  parameter int NBUF       = 4,
  parameter int LINE_BYTES = 64,
  parameter int BEAT_BYTES = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      st_valid,
  output logic                      st_ready,
  input  logic [AW-1:0]             st_addr,
  input  logic [BEAT_BYTES*8-1:0]   st_data,
  input  logic [BEAT_BYTES-1:0]     st_be,
  input  logic                      st_uncached,
  input  logic                      flush_req,
  output logic                      flush_done,
  output logic                      rfo_req,
  output logic [AW-1:0]             rfo_addr,
  output logic [$clog2(NBUF)-1:0]   rfo_tag,
  input  logic                      rfo_ack,
  input  logic [$clog2(NBUF)-1:0]   rfo_ack_tag,
  output logic                      bus_req,
  input  logic                      bus_ack,
  output logic [AW-1:0]             bus_addr,
  output logic                      bus_full,
  output logic [BEAT_BYTES*8-1:0]   bus_data,
  output logic [BEAT_BYTES-1:0]     bus_be
);
  localparam int BEATS    = LINE_BYTES / BEAT_BYTES;
  localparam int OFFW     = $clog2(LINE_BYTES);
  localparam int BOFF     = $clog2(BEAT_BYTES);
  localparam int BSELW    = $clog2(BEATS);
  localparam int TAGW     = $clog2(NBUF);
  localparam int LAW      = AW - OFFW;
  localparam int BEATBITS = BEAT_BYTES * 8;

  // Ring of line buffers; slots head..head+count-1 are held, oldest first.
  logic [NBUF-1:0]                             vld, rpend;
  logic [NBUF-1:0][LAW-1:0]                    ltag;
  logic [NBUF-1:0][BEATS-1:0][BEAT_BYTES-1:0]  bmask;
  logic [TAGW-1:0]                             head, tail, wr_idx;
  logic [TAGW:0]                               count;
  wcsb_state_e                                 state;
  logic                                        flushing, done_q;
  logic [BEATS-1:0]                            rem, chunk_any;
  logic [AW-1:0]                               uc_addr;
  logic [BEATBITS-1:0]                         uc_data, beat_data;
  logic [BEAT_BYTES-1:0]                       uc_be;
  logic                                        rfo_q;
  logic [LAW-1:0]                              rfo_line_q;
  logic [TAGW-1:0]                             rfo_tag_q;

  logic [LAW-1:0]   st_line;
  logic [BSELW-1:0] st_chunk, beat_idx;
  logic hit, order_block, full_set, beat_any, drain_wait, head_full, release_buf;
  logic [TAGW-1:0] hit_idx;
  logic do_merge, do_alloc, do_uc, start_drain, fire_done;

  assign st_line  = st_addr[AW-1:OFFW];
  assign st_chunk = st_addr[OFFW-1:BOFF];
  assign tail     = head + count[TAGW-1:0];
  assign full_set = (count == (TAGW+1)'(NBUF));
  assign wr_idx   = do_alloc ? tail : hit_idx;

  wcsb_match #(.NBUF(NBUF), .LAW(LAW)) match_i (
    .vld(vld), .rpend(rpend), .ltag(ltag), .head(head), .key(st_line),
    .hit(hit), .hit_idx(hit_idx), .order_block(order_block)
  );

  for (genvar k = 0; k < BEATS; k++) begin : g_chunk
    assign chunk_any[k] = |bmask[head][k];
  end

  wcsb_pick #(.N(BEATS)) pick_i (.req(rem), .any(beat_any), .idx(beat_idx));

  // Byte lanes: one storage array per byte position of a beat.
  for (genvar gb = 0; gb < BEAT_BYTES; gb++) begin : g_lane
    logic [NBUF-1:0][BEATS-1:0][7:0] lane;
    always_ff @(posedge clk) begin
      if ((do_alloc || do_merge) && st_be[gb]) lane[wr_idx][st_chunk] <= st_data[gb*8 +: 8];
    end
    assign beat_data[gb*8 +: 8] = lane[head][beat_idx];
  end

  // Store-side decision, made only when no drain or uncached beat is in flight.
  always_comb begin
    st_ready = 1'b0; do_merge = 1'b0; do_alloc = 1'b0;
    do_uc = 1'b0; start_drain = 1'b0; fire_done = 1'b0;
    if (state == S_IDLE) begin
      if (flushing) begin
        if (count != '0) start_drain = 1'b1;
        else fire_done = 1'b1;
      end else if (st_valid) begin
        if (st_uncached) begin
          if (count != '0) start_drain = 1'b1;
          else begin st_ready = 1'b1; do_uc = 1'b1; end
        end else if (hit) begin
          if (!order_block) begin st_ready = 1'b1; do_merge = 1'b1; end
        end else if (full_set) begin
          start_drain = 1'b1;
        end else begin
          st_ready = 1'b1; do_alloc = 1'b1;
        end
      end
    end
  end

  // Bus side.
  assign drain_wait  = rpend[head];
  assign head_full   = &bmask[head];
  assign release_buf = (state == S_DRAIN) && !drain_wait && !beat_any;

  always_comb begin
    bus_req  = 1'b0;
    bus_full = 1'b0;
    bus_addr = {ltag[head], beat_idx, {BOFF{1'b0}}};
    bus_data = beat_data;
    bus_be   = bmask[head][beat_idx];
    if (state == S_UNCACHED) begin
      bus_req  = 1'b1;
      bus_addr = uc_addr;
      bus_data = uc_data;
      bus_be   = uc_be;
    end else if (state == S_DRAIN) begin
      bus_req  = !drain_wait && beat_any;
      bus_full = head_full;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld <= '0; rpend <= '0; ltag <= '0; bmask <= '0;
      head <= '0; count <= '0; state <= S_IDLE;
      flushing <= 1'b0; done_q <= 1'b0; rem <= '0;
      uc_addr <= '0; uc_data <= '0; uc_be <= '0;
      rfo_q <= 1'b0; rfo_line_q <= '0; rfo_tag_q <= '0;
    end else begin
      rfo_q  <= 1'b0;
      done_q <= fire_done;
      if (flush_req) flushing <= 1'b1;
      else if (fire_done) flushing <= 1'b0;
      if (rfo_ack) rpend[rfo_ack_tag] <= 1'b0;
      case (state)
        S_IDLE: begin
          if (start_drain) begin
            state <= S_DRAIN;
            rem   <= chunk_any;
          end else if (do_uc) begin
            state   <= S_UNCACHED;
            uc_addr <= st_addr;
            uc_data <= st_data;
            uc_be   <= st_be;
          end
        end
        S_DRAIN: begin
          if (bus_req && bus_ack) begin
            rem[beat_idx] <= 1'b0;
          end else if (release_buf) begin
            vld[head]   <= 1'b0;
            bmask[head] <= '0;
            head        <= head + 1'b1;
            count       <= count - 1'b1;
            state       <= S_IDLE;
          end
        end
        default: if (bus_ack) state <= S_IDLE;
      endcase
      if (do_alloc) begin
        vld[tail]   <= 1'b1;
        ltag[tail]  <= st_line;
        rpend[tail] <= 1'b1;
        count       <= count + 1'b1;
        rfo_q       <= 1'b1;
        rfo_line_q  <= st_line;
        rfo_tag_q   <= tail;
      end
      if (do_alloc || do_merge) bmask[wr_idx][st_chunk] <= bmask[wr_idx][st_chunk] | st_be;
    end
  end

  assign flush_done = done_q;
  assign rfo_req    = rfo_q;
  assign rfo_addr   = {rfo_line_q, {OFFW{1'b0}}};
  assign rfo_tag    = rfo_tag_q;
endmodule

// File: rtl/wcsb_checker.sv
module wcsb_checker #(
  parameter int NBUF       = 4,
  parameter int AW         = 32,
  parameter int BEAT_BYTES = 8,
  localparam int TAGW = $clog2(NBUF)
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    st_valid,
  input logic                    st_ready,
  input logic                    st_uncached,
  input logic                    flush_req,
  input logic                    flush_done,
  input logic                    rfo_req,
  input logic                    bus_req,
  input logic                    bus_ack,
  input logic                    bus_full,
  input logic [AW-1:0]           bus_addr,
  input logic [BEAT_BYTES*8-1:0] bus_data,
  input logic [BEAT_BYTES-1:0]   bus_be,
  input logic [TAGW:0]           count,
  input logic                    hit,
  input logic                    order_block,
  input logic                    drain_wait
);
  assert_buf_limit_R1: assert property (@(posedge clk) disable iff (!rst_n)
    count <= (TAGW+1)'(NBUF));

  assert_rfo_after_accept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rfo_req |-> $past(st_valid && st_ready && !st_uncached));

  assert_order_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && !st_uncached && hit && order_block) |-> !st_ready);

  assert_uc_after_drain_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && st_ready && st_uncached) |-> count == '0);

  assert_flush_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |=> !st_ready);

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush_done |=> !flush_done);

  assert_rfo_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    drain_wait |-> !bus_req);

  assert_beat_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_data)
                               && $stable(bus_be) && $stable(bus_full)));
endmodule

bind wc_store_buffer wcsb_checker #(.NBUF(NBUF), .AW(AW), .BEAT_BYTES(BEAT_BYTES)) chk_i (
  .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready),
  .st_uncached(st_uncached), .flush_req(flush_req), .flush_done(flush_done),
  .rfo_req(rfo_req), .bus_req(bus_req), .bus_ack(bus_ack), .bus_full(bus_full),
  .bus_addr(bus_addr), .bus_data(bus_data), .bus_be(bus_be), .count(count),
  .hit(hit), .order_block(order_block), .drain_wait(drain_wait)
);

// File: tb/wc_store_buffer_tb_top.sv
`timescale 1ns/1ps
module wc_store_buffer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        st_valid = 1'b0, st_ready, st_uncached = 1'b0;
  logic [31:0] st_addr = '0;
  logic [63:0] st_data = '0;
  logic [7:0]  st_be = '0;
  logic        flush_req = 1'b0, flush_done;
  logic        rfo_req, rfo_ack = 1'b0;
  logic [31:0] rfo_addr;
  logic [1:0]  rfo_tag, rfo_ack_tag = '0;
  logic        bus_req, bus_ack = 1'b0, bus_full;
  logic [31:0] bus_addr;
  logic [63:0] bus_data;
  logic [7:0]  bus_be;

  always #5 clk = ~clk;

  wc_store_buffer dut_i (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready),
    .st_addr(st_addr), .st_data(st_data), .st_be(st_be), .st_uncached(st_uncached),
    .flush_req(flush_req), .flush_done(flush_done), .rfo_req(rfo_req),
    .rfo_addr(rfo_addr), .rfo_tag(rfo_tag), .rfo_ack(rfo_ack),
    .rfo_ack_tag(rfo_ack_tag), .bus_req(bus_req), .bus_ack(bus_ack),
    .bus_addr(bus_addr), .bus_full(bus_full), .bus_data(bus_data), .bus_be(bus_be)
  );

  int vecs = 0, errs = 0;
  int nb = 0, nr = 0, nd = 0, hold_err = 0, slow_cnt = 0;
  logic [31:0] lg_addr [64];
  logic [63:0] lg_data [64];
  logic [7:0]  lg_be   [64];
  logic        lg_full [64];
  logic [1:0]  last_tag = '0;
  logic [31:0] last_raddr = '0;
  logic auto_rfo = 1'b1, slow_bus = 1'b0, man_req = 1'b0, ack_pend = 1'b0, unacked = 1'b0;
  logic [1:0]  man_tag = '0, ack_tag = '0;
  logic [31:0] p_addr; logic [63:0] p_data; logic [7:0] p_be; logic p_full;

  function automatic logic [63:0] pat(input logic [31:0] a);
    return {a ^ 32'hA5A5_0000, ~a};
  endfunction

  function automatic logic [63:0] bmsk(input logic [7:0] be);
    logic [63:0] m;
    for (int b = 0; b < 8; b++) m[b*8 +: 8] = {8{be[b]}};
    return m;
  endfunction

  task automatic check(input logic ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Bus and ownership responders, all on the falling edge.
  always @(negedge clk) begin
    if (bus_req) begin
      if (unacked && (bus_addr != p_addr || bus_data != p_data || bus_be != p_be || bus_full != p_full))
        hold_err++;
      slow_cnt++;
      if (!slow_bus || slow_cnt >= 3) begin
        if (nb < 64) begin
          lg_addr[nb] = bus_addr; lg_data[nb] = bus_data;
          lg_be[nb] = bus_be; lg_full[nb] = bus_full;
        end
        nb++; bus_ack = 1'b1; slow_cnt = 0; unacked = 1'b0;
      end else begin
        bus_ack = 1'b0; unacked = 1'b1;
        p_addr = bus_addr; p_data = bus_data; p_be = bus_be; p_full = bus_full;
      end
    end else begin
      bus_ack = 1'b0; unacked = 1'b0;
    end
    if (rfo_req) begin nr++; last_tag = rfo_tag; last_raddr = rfo_addr; end
    if (flush_done) nd++;
    rfo_ack = 1'b0;
    if (ack_pend) begin rfo_ack = 1'b1; rfo_ack_tag = ack_tag; ack_pend = 1'b0; end
    if (auto_rfo && rfo_req) begin ack_pend = 1'b1; ack_tag = rfo_tag; end
    if (man_req) begin ack_pend = 1'b1; ack_tag = man_tag; man_req = 1'b0; end
  end

  task automatic do_store(input logic [31:0] a, input logic [7:0] be, input logic uc);
    @(negedge clk);
    st_addr = a; st_data = pat(a); st_be = be; st_uncached = uc; st_valid = 1'b1;
    #1;
    while (!st_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    st_valid = 1'b0;
    @(negedge clk); #1;
  endtask

  task automatic do_flush();
    int start = nd;
    int cyc = 0;
    @(negedge clk); flush_req = 1'b1;
    @(negedge clk); flush_req = 1'b0;
    while (nd == start && cyc < 500) begin @(negedge clk); #1; cyc++; end
    check(nd == start + 1, "R8", "flush done count", nd - start, 1);
  endtask

  task automatic man_ack(input logic [1:0] t);
    @(negedge clk); #1; man_tag = t; man_req = 1'b1;
    repeat (3) @(negedge clk);
    #1;
  endtask

  task automatic t_reset();
    @(negedge clk); #1;
    check(!bus_req && !rfo_req && !flush_done, "R11", "outputs idle",
          {bus_req, rfo_req, flush_done}, 0);
    begin
      int b0 = nb;
      do_flush();
      check(nb == b0, "R11", "beats on empty flush", nb - b0, 0);
    end
  endtask

  task automatic t_full();
    logic [31:0] la = 32'h0000_1000;
    int b0 = nb, r0 = nr;
    for (int k = 0; k < 8; k++) do_store(la + 8*k, 8'hFF, 1'b0);
    check(nr == r0 + 1, "R5", "one rfo per new line", nr - r0, 1);
    check(last_raddr == la, "R5", "rfo line address", last_raddr, la);
    do_flush();
    check(nb == b0 + 8, "R3", "full line beat count", nb - b0, 8);
    for (int k = 0; k < 8; k++) begin
      check(lg_addr[b0+k] == la + 8*k, "R3", "burst beat address", lg_addr[b0+k], la + 8*k);
      check(lg_full[b0+k] == 1'b1, "R3", "burst flag", lg_full[b0+k], 1);
      check(lg_data[b0+k] == pat(la + 8*k), "R3", "burst data", lg_data[b0+k], pat(la + 8*k));
      check(lg_be[b0+k] == 8'hFF, "R3", "burst enables", lg_be[b0+k], 8'hFF);
    end
  endtask

  task automatic t_partial();
    logic [31:0] la = 32'h0000_1000;
    int b0 = nb, r0 = nr;
    do_store(la, 8'h0F, 1'b0);
    do_store(la + 40, 8'hF0, 1'b0);
    do_store(la + 40, 8'h01, 1'b0);
    check(nr == r0 + 1, "R2", "merge issues no new rfo", nr - r0, 1);
    do_flush();
    check(nb == b0 + 2, "R4", "sparse beat count (mask cleared R2)", nb - b0, 2);
    check(lg_addr[b0] == la && lg_be[b0] == 8'h0F && !lg_full[b0], "R4", "chunk0 beat",
          {lg_addr[b0], lg_be[b0]}, {la, 8'h0F});
    check(lg_addr[b0+1] == la + 40 && lg_be[b0+1] == 8'hF1, "R2", "merged chunk5 beat",
          {lg_addr[b0+1], lg_be[b0+1]}, {la + 32'd40, 8'hF1});
    check((lg_data[b0+1] & bmsk(8'hF1)) == (pat(la + 40) & bmsk(8'hF1)), "R4", "merged data",
          lg_data[b0+1] & bmsk(8'hF1), pat(la + 40) & bmsk(8'hF1));
  endtask

  task automatic t_63();
    logic [31:0] lb = 32'h0000_3C40;
    int b0 = nb;
    slow_bus = 1'b1;
    for (int k = 0; k < 8; k++) do_store(lb + 8*k, (k == 7) ? 8'h7F : 8'hFF, 1'b0);
    do_flush();
    slow_bus = 1'b0;
    check(nb == b0 + 8, "R4", "63-byte line beat count", nb - b0, 8);
    for (int k = 0; k < 8; k++)
      check(!lg_full[b0+k] && lg_addr[b0+k] == lb + 8*k, "R4", "partial beat order",
            {lg_full[b0+k], lg_addr[b0+k]}, {1'b0, lb + 8*k});
    check(lg_be[b0+7] == 8'h7F, "R4", "last chunk enables", lg_be[b0+7], 8'h7F);
    check(hold_err == 0, "R10", "beat held until ack", hold_err, 0);
  endtask

  task automatic t_evict();
    int b0 = nb, r0 = nr;
    for (int i = 0; i < 4; i++) do_store(32'h2000 + 64*i, 8'hFF, 1'b0);
    check(nb == b0, "R1", "no drain with four held", nb - b0, 0);
    do_store(32'h2100, 8'hFF, 1'b0);
    check(nb == b0 + 1 && lg_addr[b0] == 32'h2000, "R1", "oldest evicted first",
          lg_addr[b0], 32'h2000);
    check(nr == r0 + 5, "R5", "rfo per line", nr - r0, 5);
    do_flush();
    for (int i = 1; i < 5; i++)
      check(lg_addr[b0+i] == 32'h2000 + 64*i, "R8", "flush in allocation order",
            lg_addr[b0+i], 32'h2000 + 64*i);
  endtask

  task automatic t_uncached();
    int b0 = nb, r0 = nr, w = 0;
    do_store(32'h0000_4010, 8'hFF, 1'b0);
    do_store(32'h8000_0010, 8'h3C, 1'b1);
    while (nb < b0 + 2 && w < 50) begin @(negedge clk); #1; w++; end
    check(nb == b0 + 2, "R7", "two beats", nb - b0, 2);
    check(lg_addr[b0] == 32'h4010, "R7", "held line drains first", lg_addr[b0], 32'h4010);
    check(lg_addr[b0+1] == 32'h8000_0010 && !lg_full[b0+1] && lg_be[b0+1] == 8'h3C,
          "R7", "uncached beat", {lg_addr[b0+1], lg_be[b0+1]}, {32'h8000_0010, 8'h3C});
    check(lg_data[b0+1] == pat(32'h8000_0010), "R7", "uncached data",
          lg_data[b0+1], pat(32'h8000_0010));
    check(nr == r0 + 1, "R7", "no rfo for uncached", nr - r0, 1);
  endtask

  task automatic t_order();
    logic [1:0] ta, tb;
    int b0, early = 0, w = 0;
    auto_rfo = 1'b0;
    b0 = nb;
    do_store(32'h5000, 8'hFF, 1'b0); ta = last_tag;
    man_ack(ta);
    do_store(32'h5040, 8'hFF, 1'b0); tb = last_tag;
    @(negedge clk);
    st_addr = 32'h5008; st_data = pat(32'h5008); st_be = 8'hFF; st_uncached = 1'b0; st_valid = 1'b1;
    repeat (6) begin #1; if (st_ready) early++; @(negedge clk); end
    check(early == 0, "R6", "older-line store held", early, 0);
    man_tag = tb; man_req = 1'b1;
    #1;
    while (!st_ready && w < 20) begin @(negedge clk); #1; w++; end
    check(st_ready, "R6", "released after answer", st_ready, 1);
    @(posedge clk); #1; st_valid = 1'b0;
    auto_rfo = 1'b1;
    do_flush();
    check(nb == b0 + 3 && lg_addr[b0+1] == 32'h5008 && lg_addr[b0+2] == 32'h5040, "R6",
          "visible order", lg_addr[b0+2], 32'h5040);
  endtask

  task automatic t_gate();
    int b0 = nb, d0 = nd, w = 0;
    logic [1:0] tf;
    auto_rfo = 1'b0;
    do_store(32'h6000, 8'h01, 1'b0); tf = last_tag;
    @(negedge clk); flush_req = 1'b1;
    @(negedge clk); flush_req = 1'b0;
    repeat (10) @(negedge clk);
    #1;
    check(nb == b0 && nd == d0, "R9", "no drain before answer", nb - b0, 0);
    man_ack(tf);
    while (nd == d0 && w < 50) begin @(negedge clk); #1; w++; end
    check(nb == b0 + 1 && lg_addr[b0] == 32'h6000, "R9", "drain after answer",
          lg_addr[b0], 32'h6000);
    auto_rfo = 1'b1;
  endtask

  task automatic t_flush_block();
    int b0 = nb, d0 = nd, viol = 0, w = 0;
    do_store(32'h7018, 8'hFF, 1'b0);
    do_store(32'h7040, 8'hFF, 1'b0);
    @(negedge clk); flush_req = 1'b1;
    @(negedge clk); flush_req = 1'b0;
    st_addr = 32'h7080; st_data = pat(32'h7080); st_be = 8'hFF; st_uncached = 1'b0; st_valid = 1'b1;
    while (w < 200) begin
      #1;
      if (nd != d0) break;
      if (st_ready) viol++;
      @(negedge clk); w++;
    end
    check(viol == 0, "R8", "no store taken during flush", viol, 0);
    check(nb == b0 + 2 && lg_addr[b0] == 32'h7018 && lg_addr[b0+1] == 32'h7040, "R8",
          "flush beat order", lg_addr[b0], 32'h7018);
    while (!st_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1; st_valid = 1'b0;
    repeat (3) @(negedge clk);
    check(nd == d0 + 1, "R8", "single done pulse", nd - d0, 1);
    do_flush();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_full();
    t_partial();
    t_63();
    t_evict();
    t_uncached();
    t_order();
    t_gate();
    t_flush_block();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    vecs++; errs++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule